// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block moves data units, one per request, from a source address to a destination address over a simple single-master memory bus. A CPU programs it through a small register file: a control register, a request-source select register, and 16-bit source, destination and count registers. Each address register has a reload copy. Two banks of sixteen single-cycle hardware request inputs, or a software trigger, can start a transfer. The selected request is latched as a pending flag. While the channel is enabled, each pending request becomes one bus read followed by one bus write.

Each address either stays put or steps forward after every unit. The unit is one byte or one 16-bit word. When the count runs out, the channel either switches itself off (single mode) or reloads its addresses and count and keeps running (repeat mode). In both modes a one-cycle `done` pulse marks the expiry.

Top module: `dma_channel`

## Requirements
- R1: After reset the control register (address 0) and the select register (address 1) read 0x00, `bus_req` is low and `done` is low.
- R2: Control bits 7 and 6 and select bits 7, 5 and 4 always read 0, and writes to them have no stored effect.
- R3: Control bit 2 is the pending flag. A selected request sets it. A CPU write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. Further requests that arrive while the flag is set merge into the single pending request.
- R4: Select bit 6 chooses the bank (0 = `req_basic`, 1 = `req_ext`) and select bits 3..0 index the input within that bank. Unselected inputs are ignored. Requests are ignored while control bit 3 (enable) is 0.
- R5: A write to the select register with bit 7 = 1, bit 6 = 0 and bits 3..0 = 0001 makes a software request. Any other bank or code with bit 7 set makes none.
- R6: Each pending request produces exactly one bus read at the source address, then one bus write to the destination address. `bus_byte` equals control bit 0 (1 = 8-bit unit, 0 = 16-bit unit). For 8-bit units the written data is the low byte of the read data with the upper byte zero.
- R7: Control bit 4 (source) and bit 5 (destination) select the address direction: 0 keeps the address fixed, and 1 adds 1 (8-bit unit) or 2 (16-bit unit) after each unit. When both bits are 1, the destination is held fixed.
- R8: In single mode (control bit 1 = 0), the unit that takes the count from 1 to 0 clears the enable bit and raises `done` for exactly one cycle. A count loaded as 0 stands for 65536 units.
- R9: In repeat mode (control bit 1 = 1), count expiry reloads the source, destination and count from their reload copies, pulses `done`, and leaves the channel enabled.
- R10: Addresses 2, 3 and 4 hold the source, destination and count. A write loads both the working register and its reload copy, and a read returns the working value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_addr | input | 3 | CPU register address |
| reg_wdata | input | 16 | CPU write data |
| reg_rdata | output | 16 | CPU read data for `reg_addr` (combinational) |
| req_basic | input | 16 | Basic bank of request pulses |
| req_ext | input | 16 | Extended bank of request pulses |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_byte | output | 1 | 1 = 8-bit unit, 0 = 16-bit unit |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | Bus cycle completes this cycle |
| done | output | 1 | One-cycle pulse when the count expires |

## Verification
A hardware request pulse, or a software-trigger register write, is registered into the pending flag at clock edge E. The read phase starts after edge E+1, and the write phase is on the bus after edge E+2 when the bus acknowledges at once. After edge E+3, the updated addresses, the count, the cleared enable and the `done` pulse can be seen. The driver stamps every expected write with its due cycle, E+2. The monitor compares the address, data, size and cycle of each write it sees. Cases with a stalled bus carry no due cycle. Register reads are sampled only after the driver has waited past E+3.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } bus_st_e;

    // control register layout, bit 5 down to bit 0
    typedef struct packed {
        logic ddir;
        logic sdir;
        logic en;
        logic pend;
        logic rep;
        logic unit8;
    } ctrl_t;

    localparam int unsigned A_CTRL = 0;
    localparam int unsigned A_SEL  = 1;
    localparam int unsigned A_SRC  = 2;
    localparam int unsigned A_DST  = 3;
    localparam int unsigned A_CNT  = 4;

    localparam int unsigned SEL_BANK_BIT = 6;
    localparam int unsigned SEL_SW_BIT   = 7;

endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
    parameter int NSRC = 16,
    localparam int SELW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] req_basic,
    input  logic [NSRC-1:0] req_ext,
    input  logic [SELW-1:0] code,
    input  logic            bank,
    input  logic            enable,
    input  logic            sw_fire,
    output logic            hit
);
    logic hw_hit;

    always_comb begin
        hw_hit = bank ? req_ext[code] : req_basic[code];
        hit    = enable && (hw_hit || sw_fire);
    end
endmodule

// File: rtl/dma_step.sv
module dma_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_cur,
    input  logic          inc,
    input  logic          unit8,
    output logic [AW-1:0] addr_nx
);
    logic [AW-1:0] stride;

    always_comb begin
        stride  = unit8 ? AW'(1) : AW'(2);
        addr_nx = inc ? addr_cur + stride : addr_cur;
    end
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          unit8,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_byte,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          take,
    output logic          unit_done
);
    typedef struct packed {
        bus_st_e       st;
        logic [DW-1:0] data;
    } fsm_s;

    fsm_s q, d;

    always_comb begin
        d         = q;
        take      = 1'b0;
        unit_done = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_byte  = unit8;
        bus_addr  = src_addr;
        bus_wdata = q.data;
        case (q.st)
            ST_IDLE: begin
                if (go) begin
                    take = 1'b1;
                    d.st = ST_RD;
                end
            end
            ST_RD: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    d.data = unit8 ? {{(DW-8){1'b0}}, bus_rdata[7:0]} : bus_rdata;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dst_addr;
                if (bus_ack) begin
                    unit_done = 1'b1;
                    d.st      = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.data <= '0;
        end else begin
            q <= d;
        end
    end

    // R6: an acknowledged read is always followed by the write phase
    a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

    // R6: a new unit is only taken while the bus is quiet
    a_r6_take_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !bus_req);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int NSRC = 16,
    parameter int RAW  = 3,
    localparam int SELW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    input  logic [NSRC-1:0] req_basic,
    input  logic [NSRC-1:0] req_ext,
    output logic            bus_req,
    output logic            bus_we,
    output logic            bus_byte,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ack,
    output logic            done
);
    typedef struct packed {
        ctrl_t           ctrl;
        logic [SELW-1:0] code;
        logic            bank;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [AW-1:0]   src_rl;
        logic [AW-1:0]   dst_rl;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   cnt_rl;
        logic            done;
    } regs_s;

    regs_s q, d;

    logic          wr_ctrl, wr_sel, wr_src, wr_dst, wr_cnt;
    logic          sw_fire, hit, take, unit_done, last_unit;
    logic [AW-1:0] ptr_cur [2];
    logic [AW-1:0] ptr_nx  [2];
    logic          ptr_inc [2];

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == RAW'(A_CTRL));
        wr_sel  = reg_wr && (reg_addr == RAW'(A_SEL));
        wr_src  = reg_wr && (reg_addr == RAW'(A_SRC));
        wr_dst  = reg_wr && (reg_addr == RAW'(A_DST));
        wr_cnt  = reg_wr && (reg_addr == RAW'(A_CNT));
        sw_fire = wr_sel && reg_wdata[SEL_SW_BIT] && !reg_wdata[SEL_BANK_BIT]
                  && (reg_wdata[3:0] == 4'b0001);
        last_unit  = (q.cnt == CW'(1));
        ptr_cur[0] = q.src;
        ptr_cur[1] = q.dst;
        ptr_inc[0] = q.ctrl.sdir;
        ptr_inc[1] = q.ctrl.ddir && !q.ctrl.sdir;
    end

    dma_req_sel #(.NSRC(NSRC)) u_req_sel (
        .req_basic (req_basic),
        .req_ext   (req_ext),
        .code      (q.code),
        .bank      (q.bank),
        .enable    (q.ctrl.en),
        .sw_fire   (sw_fire),
        .hit       (hit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        dma_step #(.AW(AW)) u_step (
            .addr_cur (ptr_cur[g]),
            .inc      (ptr_inc[g]),
            .unit8    (q.ctrl.unit8),
            .addr_nx  (ptr_nx[g])
        );
    end

    dma_bus_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (q.ctrl.en && q.ctrl.pend),
        .unit8     (q.ctrl.unit8),
        .src_addr  (q.src),
        .dst_addr  (q.dst),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .take      (take),
        .unit_done (unit_done)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;

        // unit completion: advance, count down, maybe reload
        if (unit_done) begin
            d.src = ptr_nx[0];
            d.dst = ptr_nx[1];
            d.cnt = q.cnt - CW'(1);
            if (last_unit) begin
                d.done = 1'b1;
                if (q.ctrl.rep) begin
                    d.src = q.src_rl;
                    d.dst = q.dst_rl;
                    d.cnt = q.cnt_rl;
                end
            end
        end

        // CPU writes win over engine updates
        if (wr_ctrl) begin
            d.ctrl.unit8 = reg_wdata[0];
            d.ctrl.rep   = reg_wdata[1];
            d.ctrl.en    = reg_wdata[3];
            d.ctrl.sdir  = reg_wdata[4];
            d.ctrl.ddir  = reg_wdata[5];
            if (!reg_wdata[2]) d.ctrl.pend = 1'b0;
        end
        if (wr_sel) begin
            d.code = reg_wdata[SELW-1:0];
            d.bank = reg_wdata[SEL_BANK_BIT];
        end
        if (wr_src) begin
            d.src    = reg_wdata;
            d.src_rl = reg_wdata;
        end
        if (wr_dst) begin
            d.dst    = reg_wdata;
            d.dst_rl = reg_wdata;
        end
        if (wr_cnt) begin
            d.cnt    = reg_wdata[CW-1:0];
            d.cnt_rl = reg_wdata[CW-1:0];
        end

        // hardware overrides
        if (unit_done && last_unit && !q.ctrl.rep) d.ctrl.en = 1'b0;
        if (take) d.ctrl.pend = 1'b0;
        if (hit)  d.ctrl.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(A_CTRL): reg_rdata[5:0] = q.ctrl;
            RAW'(A_SEL): begin
                reg_rdata[SELW-1:0]     = q.code;
                reg_rdata[SEL_BANK_BIT] = q.bank;
            end
            RAW'(A_SRC): reg_rdata = q.src;
            RAW'(A_DST): reg_rdata = q.dst;
            RAW'(A_CNT): reg_rdata[CW-1:0] = q.cnt;
            default:     reg_rdata = '0;
        endcase
        done = q.done;
    end

    // R3: a taken request leaves no pending flag unless a new one arrived
    a_r3_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !hit) |=> !q.ctrl.pend);

    // R4: a disabled channel never picks up a pending request
    a_r4_disabled_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctrl.en && !q.ctrl.pend) |=> !q.ctrl.pend);

    // R6: the write phase addresses the working destination
    a_r6_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_addr == q.dst));

    // R7: a fixed source does not move after a non-final unit
    a_r7_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && !q.ctrl.sdir && !wr_src && !last_unit) |=> (q.src == $past(q.src)));

    // R8: after a done pulse a single-mode channel is switched off
    a_r8_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (q.ctrl.rep || !q.ctrl.en));

    // R8: done lasts one cycle unless another unit finished
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !unit_done) |=> !done);
endmodule

// File: tb/dma_channel_bench.sv
module dma_channel_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        logic        byt;
        int          due;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] req_basic = '0;
    logic [15:0] req_ext = '0;
    logic        bus_req, bus_we, bus_byte, done;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ack;
    logic        hold = 1'b0;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    int done_seen = 0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign bus_ack   = bus_req && !hold;
    assign bus_rdata = bus_addr ^ 16'hA5C3;

    dma_channel u_dma_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_basic(req_basic),
        .req_ext(req_ext), .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .done(done)
    );

    function automatic logic [15:0] mem_of(input logic [15:0] a, input logic byt);
        logic [15:0] v;
        v = a ^ 16'hA5C3;
        return byt ? {8'h00, v[7:0]} : v;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare each bus write with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) done_seen++;
        if (rst_n && bus_req && bus_we && bus_ack) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected write", {bus_addr, bus_wdata}, 32'h0);
            end else begin
                item_t e;
                e = sb.pop_front();
                check(bus_addr == e.addr, "R7 write address", bus_addr, e.addr);
                check(bus_wdata == e.data, "R6 write data", bus_wdata, e.data);
                check(bus_byte == e.byt, "R6 unit size", bus_byte, e.byt);
                if (e.due != 0) check(cyc == e.due, "R6 write cycle", cyc, e.due);
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [15:0] src,
                             input logic byt, input int due);
        item_t e;
        e.addr = a; e.data = mem_of(src, byt); e.byt = byt; e.due = due;
        sb.push_back(e);
    endtask

    task automatic pulse(input logic ext, input int idx);
        @(negedge clk);
        if (ext) req_ext[idx] = 1'b1; else req_basic[idx] = 1'b1;
        @(negedge clk);
        req_ext = '0; req_basic = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        reg_check(3'd0, 16'h0000, "R1 control after reset");
        reg_check(3'd1, 16'h0000, "R1 select after reset");
        check(bus_req == 1'b0, "R1 bus idle", bus_req, 0);
        check(done == 1'b0, "R1 done low", done, 0);

        // R2 unused bits
        reg_write(3'd0, 16'h00C4);
        reg_check(3'd0, 16'h0000, "R2 control unused bits");
        reg_write(3'd1, 16'h00B5);
        reg_check(3'd1, 16'h0005, "R2 select unused bits");

        // R10 address/count registers
        reg_write(3'd2, 16'h0100);
        reg_write(3'd3, 16'h0200);
        reg_write(3'd4, 16'h0003);
        reg_check(3'd2, 16'h0100, "R10 source readback");
        reg_check(3'd3, 16'h0200, "R10 destination readback");
        reg_check(3'd4, 16'h0003, "R10 count readback");

        // single mode, 16-bit, source increments
        reg_write(3'd1, 16'h0005);
        reg_write(3'd0, 16'h0018);
        pulse(1'b0, 5); expect_wr(16'h0200, 16'h0100, 1'b0, cyc + 2);
        idle(6);
        reg_check(3'd2, 16'h0102, "R7 source stepped by 2");
        reg_check(3'd3, 16'h0200, "R7 destination fixed");
        reg_check(3'd4, 16'h0002, "R8 count decremented");
        pulse(1'b0, 4);
        pulse(1'b1, 5);
        idle(6);
        reg_check(3'd0, 16'h0018, "R4 unselected inputs ignored");
        pulse(1'b0, 5); expect_wr(16'h0200, 16'h0102, 1'b0, cyc + 2);
        idle(6);
        pulse(1'b0, 5); expect_wr(16'h0200, 16'h0104, 1'b0, cyc + 2);
        idle(6);
        check(done_seen == 1, "R8 done pulse count", done_seen, 1);
        reg_check(3'd0, 16'h0010, "R8 enable cleared in single mode");
        reg_check(3'd4, 16'h0000, "R8 count at zero");

        // R4 disabled channel ignores requests
        pulse(1'b0, 5);
        reg_write(3'd0, 16'h0018);
        idle(6);
        reg_check(3'd0, 16'h0018, "R4 no pending while disabled");

        // R3 pending flag with stalled bus
        hold = 1'b1;
        reg_write(3'd2, 16'h0300);
        reg_write(3'd3, 16'h0400);
        reg_write(3'd4, 16'h0005);
        pulse(1'b0, 5); expect_wr(16'h0400, 16'h0300, 1'b0, 0);
        idle(4);
        pulse(1'b0, 5);
        pulse(1'b0, 5);
        reg_check(3'd0, 16'h001C, "R3 pending set and merged");
        reg_write(3'd0, 16'h001C);
        reg_check(3'd0, 16'h001C, "R3 write one keeps pending");
        reg_write(3'd0, 16'h0018);
        reg_check(3'd0, 16'h0018, "R3 write zero clears pending");
        hold = 1'b0;
        idle(8);
        reg_check(3'd4, 16'h0004, "R3 only one unit for merged requests");
        reg_check(3'd2, 16'h0302, "R6 source after stalled unit");

        // R9 repeat, 8-bit, both directions set, software trigger (R5)
        reg_write(3'd2, 16'h0010);
        reg_write(3'd3, 16'h0020);
        reg_write(3'd4, 16'h0002);
        reg_write(3'd0, 16'h003B);
        reg_write(3'd1, 16'h0081); expect_wr(16'h0020, 16'h0010, 1'b1, cyc + 2);
        idle(6);
        reg_write(3'd1, 16'h0081); expect_wr(16'h0020, 16'h0011, 1'b1, cyc + 2);
        idle(6);
        check(done_seen == 2, "R9 done in repeat mode", done_seen, 2);
        reg_check(3'd0, 16'h003B, "R9 enable kept in repeat mode");
        reg_check(3'd2, 16'h0010, "R9 source reloaded");
        reg_check(3'd4, 16'h0002, "R9 count reloaded");
        reg_write(3'd1, 16'h0081); expect_wr(16'h0020, 16'h0010, 1'b1, cyc + 2);
        idle(6);
        reg_check(3'd2, 16'h0011, "R7 byte step of 1");
        reg_check(3'd3, 16'h0020, "R7 destination fixed when both set");

        // R5 negative software triggers
        reg_write(3'd1, 16'h00C1);
        idle(6);
        reg_check(3'd1, 16'h0041, "R5 extended bank readback");
        reg_write(3'd1, 16'h0082);
        idle(6);
        reg_check(3'd4, 16'h0001, "R5 wrong code makes no request");

        // R4 extended bank
        reg_write(3'd1, 16'h0043);
        pulse(1'b1, 3); expect_wr(16'h0020, 16'h0011, 1'b1, cyc + 2);
        idle(6);
        pulse(1'b0, 3);
        idle(10);
        check(done_seen == 3, "R9 second repeat expiry", done_seen, 3);
        check(sb.size() == 0, "R6 all expected writes seen", sb.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule